// File: doc/BRIEF.md
# Masked Compress Gather/Scatter Sequencer

This block turns a conditional element-wise update into a compressed one. On a start pulse it compares each element of an incoming condition vector against a reference value, using a selectable relation. The result is a per-element mask. From that mask it builds a list of the active element positions. It then reads only those elements from memory, adds a scalar to each one, and writes every sum back to the address it came from. Elements whose condition fails never cause a memory access.

The mask turns the branch in the loop body into data. Work is therefore proportional to the number of active elements, not to the vector length. The memory side is a single word port with separate request and write-enable signals. Read data returns in the cycle after the request. The add step is the operation stage.

Top module: `mask_compress_seq`

## Requirements
- R1: Element i is active when its condition value relates to `cmp_ref` under `cmp_mode`. The codes are 0 = equal, 1 = not equal, 2 = unsigned less than and 3 = unsigned greater or equal. Element i is held in bits [i*DATA_W +: DATA_W] of `cmp_vals`.
- R2: Exactly one read is issued per active element. Reads go in ascending element order, to address `base_addr + i*ELEM_BYTES`.
- R3: Each active element gets exactly one write. Writes follow the same ascending order to the same addresses. The write data is the word read back plus `addend`, modulo 2^DATA_W.
- R4: Memory words of inactive elements are never written. Words outside the addressed window are never written either.
- R5: When no element is active, the run ends with a `done` pulse and makes no memory request.
- R6: `busy` is high from the cycle after an accepted start until `done` rises. A start that arrives while `busy` is high is ignored and does not alter the run in progress. A memory request is only made while `busy` is high.
- R7: `done` is a single-cycle pulse. It rises after the last write of the run has been presented.
- R8: Every read of a run is issued before the first write of that run.
- R9: While reset is high, and right after it, `busy`, `done` and `mem_req` are low.
- R10: With every element active, the run performs NUM_ELEM reads and NUM_ELEM writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; sampled only while idle |
| cmp_mode | input | 2 | Relation used to build the mask |
| cmp_vals | input | NUM_ELEM*DATA_W | Condition values, one per element |
| cmp_ref | input | DATA_W | Reference value for the comparison |
| base_addr | input | ADDR_W | Byte address of element 0 |
| addend | input | DATA_W | Scalar added to each gathered operand |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_req | output | 1 | Memory access valid this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |

## Verification
A corrupted mask or position list shows up at the memory port on the first access. A wrong address, a skipped position or an extra position becomes visible on the first read that follows it. A fault in the operand buffer or in the adder shows up later, only in the scatter phase, as wrong write data. That happens a few cycles after the matching read. A sequencing fault is visible at once: a write slipping into the gather phase, or a lost or repeated `done`. A leak to inactive elements is caught when memory is compared after the run.

// File: rtl/vc_pkg.sv
package vc_pkg;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'd0,
        CMP_NE  = 2'd1,
        CMP_LTU = 2'd2,
        CMP_GEU = 2'd3
    } cmp_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUILD = 2'd1,
        ST_RUN   = 2'd2
    } top_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_GATHER  = 2'd1,
        SQ_SCATTER = 2'd2
    } seq_phase_e;

    function automatic logic cmp_hit(input cmp_mode_e mode, input logic [63:0] a,
                                     input logic [63:0] b);
        logic r;
        case (mode)
            CMP_EQ:  r = (a == b);
            CMP_NE:  r = (a != b);
            CMP_LTU: r = (a < b);
            default: r = (a >= b);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vc_mask_cmp.sv
module vc_mask_cmp #(
    parameter int NUM_ELEM = 8,
    parameter int DATA_W   = 16
) (
    input  vc_pkg::cmp_mode_e         mode,
    input  logic [NUM_ELEM*DATA_W-1:0] vals,
    input  logic [DATA_W-1:0]          ref_val,
    output logic [NUM_ELEM-1:0]        mask
);
    generate
        for (genvar i = 0; i < NUM_ELEM; i++) begin : g_lane
            assign mask[i] = vc_pkg::cmp_hit(mode, 64'(vals[i*DATA_W +: DATA_W]),
                                             64'(ref_val));
        end
    endgenerate
endmodule

// File: rtl/vc_index_build.sv
module vc_index_build #(
    parameter int NUM_ELEM = 8,
    localparam int IDX_W   = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
    localparam int CNT_W   = $clog2(NUM_ELEM + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [NUM_ELEM-1:0]       mask_in,
    output logic [NUM_ELEM*IDX_W-1:0] idx_list,
    output logic [CNT_W-1:0]          count,
    output logic                      ready
);
    logic [NUM_ELEM-1:0] rem_q;
    logic [IDX_W-1:0]    idx_q [NUM_ELEM];
    logic [CNT_W-1:0]    cnt_q;
    logic [IDX_W-1:0]    low_pos;

    // lowest set bit of the remaining mask
    always_comb begin
        low_pos = '0;
        for (int i = NUM_ELEM - 1; i >= 0; i--) begin
            if (rem_q[i]) low_pos = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= mask_in;
            cnt_q <= '0;
        end else if (rem_q != '0) begin
            rem_q[low_pos] <= 1'b0;
            cnt_q          <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!load && rem_q != '0) idx_q[cnt_q[IDX_W-1:0]] <= low_pos;
    end

    generate
        for (genvar k = 0; k < NUM_ELEM; k++) begin : g_out
            assign idx_list[k*IDX_W +: IDX_W] = idx_q[k];
        end
    endgenerate

    assign count = cnt_q;
    assign ready = (rem_q == '0);
endmodule

// File: rtl/vc_mem_seq.sv
module vc_mem_seq #(
    parameter int NUM_ELEM   = 8,
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 16,
    parameter int ELEM_BYTES = 2,
    localparam int IDX_W     = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
    localparam int CNT_W     = $clog2(NUM_ELEM + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      go,
    input  logic [CNT_W-1:0]          count,
    input  logic [NUM_ELEM*IDX_W-1:0] idx_list,
    input  logic [ADDR_W-1:0]         base,
    input  logic [DATA_W-1:0]         addend,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    output logic                      finished
);
    import vc_pkg::*;

    seq_phase_e        phase_q;
    logic [CNT_W-1:0]  iss_q, rcv_q, wr_q;
    logic              rd_pipe_q;
    logic              req_q, we_q, fin_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] buf_q [NUM_ELEM];
    logic [IDX_W-1:0]  iss_idx, wr_idx;

    assign iss_idx = idx_list[iss_q[IDX_W-1:0]*IDX_W +: IDX_W];
    assign wr_idx  = idx_list[wr_q[IDX_W-1:0]*IDX_W +: IDX_W];

    function automatic logic [ADDR_W-1:0] elem_addr(input logic [IDX_W-1:0] idx);
        return base + ADDR_W'(idx) * ADDR_W'(ELEM_BYTES);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= SQ_IDLE;
            iss_q     <= '0;
            rcv_q     <= '0;
            wr_q      <= '0;
            rd_pipe_q <= 1'b0;
            req_q     <= 1'b0;
            we_q      <= 1'b0;
            fin_q     <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
        end else begin
            fin_q     <= 1'b0;
            rd_pipe_q <= req_q && !we_q;
            case (phase_q)
                SQ_IDLE: begin
                    req_q <= 1'b0;
                    if (go) begin
                        phase_q <= SQ_GATHER;
                        iss_q   <= '0;
                        rcv_q   <= '0;
                    end
                end
                SQ_GATHER: begin
                    if (rd_pipe_q) rcv_q <= rcv_q + 1'b1;
                    if (iss_q != count) begin
                        req_q  <= 1'b1;
                        we_q   <= 1'b0;
                        addr_q <= elem_addr(iss_idx);
                        iss_q  <= iss_q + 1'b1;
                    end else begin
                        req_q <= 1'b0;
                    end
                    if (rcv_q == count) begin
                        phase_q <= SQ_SCATTER;
                        wr_q    <= '0;
                    end
                end
                SQ_SCATTER: begin
                    if (wr_q != count) begin
                        req_q   <= 1'b1;
                        we_q    <= 1'b1;
                        addr_q  <= elem_addr(wr_idx);
                        wdata_q <= buf_q[wr_q[IDX_W-1:0]];
                        wr_q    <= wr_q + 1'b1;
                    end else begin
                        req_q   <= 1'b0;
                        we_q    <= 1'b0;
                        fin_q   <= 1'b1;
                        phase_q <= SQ_IDLE;
                    end
                end
                default: phase_q <= SQ_IDLE;
            endcase
        end
    end

    // compressed operand buffer, results of the add stage
    always_ff @(posedge clk) begin
        if (phase_q == SQ_GATHER && rd_pipe_q)
            buf_q[rcv_q[IDX_W-1:0]] <= mem_rdata + addend;
    end

    assign mem_req   = req_q;
    assign mem_we    = we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign finished  = fin_q;
endmodule

// File: rtl/mask_compress_seq.sv
module mask_compress_seq #(
    parameter int NUM_ELEM   = 8,
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 16,
    parameter int ELEM_BYTES = 2,
    localparam int IDX_W     = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
    localparam int CNT_W     = $clog2(NUM_ELEM + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [1:0]                 cmp_mode,
    input  logic [NUM_ELEM*DATA_W-1:0] cmp_vals,
    input  logic [DATA_W-1:0]          cmp_ref,
    input  logic [ADDR_W-1:0]          base_addr,
    input  logic [DATA_W-1:0]          addend,
    output logic                       busy,
    output logic                       done,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    input  logic [DATA_W-1:0]          mem_rdata
);
    import vc_pkg::*;

    top_state_e                st_q;
    logic                      done_q;
    logic [ADDR_W-1:0]         base_q;
    logic [DATA_W-1:0]         add_q;
    logic [NUM_ELEM-1:0]       mask;
    logic [NUM_ELEM*IDX_W-1:0] idx_list;
    logic [CNT_W-1:0]          idx_count;
    logic                      ib_ready, ib_load, seq_go, seq_fin;

    vc_mask_cmp #(.NUM_ELEM(NUM_ELEM), .DATA_W(DATA_W)) u_cmp (
        .mode    (cmp_mode_e'(cmp_mode)),
        .vals    (cmp_vals),
        .ref_val (cmp_ref),
        .mask    (mask)
    );

    assign ib_load = (st_q == ST_IDLE) && start;

    vc_index_build #(.NUM_ELEM(NUM_ELEM)) u_idx (
        .clk      (clk),
        .rst      (rst),
        .load     (ib_load),
        .mask_in  (mask),
        .idx_list (idx_list),
        .count    (idx_count),
        .ready    (ib_ready)
    );

    assign seq_go = (st_q == ST_BUILD) && ib_ready && (idx_count != '0);

    vc_mem_seq #(
        .NUM_ELEM(NUM_ELEM), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ELEM_BYTES(ELEM_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (seq_go),
        .count     (idx_count),
        .idx_list  (idx_list),
        .base      (base_q),
        .addend    (add_q),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .finished  (seq_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b0;
            base_q <= '0;
            add_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q <= base_addr;
                        add_q  <= addend;
                        st_q   <= ST_BUILD;
                    end
                end
                ST_BUILD: begin
                    if (ib_ready) begin
                        if (idx_count == '0) begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            st_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (seq_fin) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st_q != ST_IDLE);
    assign done = done_q;
endmodule

// File: rtl/vc_compress_checker.sv
module vc_compress_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    logic              seen_wr_q, rd_any_q;
    logic [ADDR_W-1:0] last_rd_q;
    logic [15:0]       rd_cnt_q, wr_cnt_q;
    logic              new_run;

    assign new_run = start && !busy;

    always_ff @(posedge clk) begin
        if (rst || new_run) begin
            seen_wr_q <= 1'b0;
            rd_any_q  <= 1'b0;
            last_rd_q <= '0;
            rd_cnt_q  <= '0;
            wr_cnt_q  <= '0;
        end else if (mem_req) begin
            if (mem_we) begin
                seen_wr_q <= 1'b1;
                wr_cnt_q  <= wr_cnt_q + 1'b1;
            end else begin
                rd_any_q  <= 1'b1;
                last_rd_q <= mem_addr;
                rd_cnt_q  <= rd_cnt_q + 1'b1;
            end
        end
    end

    assert_req_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_gather_before_scatter_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !seen_wr_q);

    assert_read_ascending_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && rd_any_q) |-> (mem_addr > last_rd_q));

    assert_write_per_read_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (wr_cnt_q < rd_cnt_q));

    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);
endmodule

bind mask_compress_seq vc_compress_checker #(.ADDR_W(ADDR_W)) u_vc_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/mask_compress_seq_bench.sv
module mask_compress_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;
    localparam int DW = 16;
    localparam int AW = 16;
    localparam int EB = 2;
    localparam int MW = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] cmp_mode = '0;
    logic [NE*DW-1:0] cmp_vals = '0;
    logic [DW-1:0] cmp_ref = '0;
    logic [AW-1:0] base_addr = '0;
    logic [DW-1:0] addend = '0;
    logic busy, done, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    logic [DW-1:0] mem [MW];
    logic [DW-1:0] exp_mem [MW];
    logic [AW-1:0] rd_q [$];
    logic [AW+DW-1:0] wr_q [$];
    int n_tests = 0;
    int n_fail = 0;
    int acc_cnt = 0;
    logic wr_seen = 1'b0;
    bit ended = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mask_compress_seq u_mask_compress_seq (
        .clk(clk), .rst(rst), .start(start), .cmp_mode(cmp_mode), .cmp_vals(cmp_vals),
        .cmp_ref(cmp_ref), .base_addr(base_addr), .addend(addend), .busy(busy),
        .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] init_word(input int i);
        return DW'(16'h1000 + i * 16'h0111);
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MW; i++) mem[i] <= init_word(i);
            mem_rdata <= '0;
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr[6:1]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[6:1]];
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pop expected accesses and compare
    always @(negedge clk) begin
        if (!rst && mem_req) begin
            acc_cnt++;
            if (!mem_we) begin
                check(!wr_seen, "R8 read after write", 1, 0);
                if (rd_q.size() == 0) check(0, "R2 unexpected read", mem_addr, 0);
                else begin
                    logic [AW-1:0] ea;
                    ea = rd_q.pop_front();
                    check(mem_addr == ea, "R2 read address", mem_addr, ea);
                end
            end else begin
                wr_seen = 1'b1;
                if (wr_q.size() == 0) check(0, "R4 unexpected write", mem_addr, 0);
                else begin
                    logic [AW+DW-1:0] ew;
                    ew = wr_q.pop_front();
                    check(mem_addr == ew[AW+DW-1:DW], "R3 write address", mem_addr, ew[AW+DW-1:DW]);
                    check(mem_wdata == ew[DW-1:0], "R3 write data", mem_wdata, ew[DW-1:0]);
                end
            end
        end
    end

    task automatic run_case(input logic [1:0] mode, input logic [NE*DW-1:0] vals,
                            input logic [DW-1:0] rv, input logic [AW-1:0] base,
                            input logic [DW-1:0] add, input bit poke, input string name);
        int nact = 0;
        int waitc = 0;
        for (int i = 0; i < NE; i++) begin
            logic [DW-1:0] v;
            logic hit;
            v = vals[i*DW +: DW];
            case (mode)
                2'd0: hit = (v == rv);
                2'd1: hit = (v != rv);
                2'd2: hit = (v < rv);
                default: hit = (v >= rv);
            endcase
            if (hit) begin
                logic [AW-1:0] a;
                logic [DW-1:0] nv;
                a = base + AW'(i * EB);
                nv = exp_mem[a[6:1]] + add;
                rd_q.push_back(a);
                wr_q.push_back({a, nv});
                exp_mem[a[6:1]] = nv;
                nact++;
            end
        end
        acc_cnt = 0;
        wr_seen = 1'b0;
        @(negedge clk);
        cmp_mode = mode; cmp_vals = vals; cmp_ref = rv; base_addr = base; addend = add;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, {"R6 busy after start ", name}, busy, 1);
        if (poke) begin
            // R6: start while busy must be ignored
            cmp_mode = 2'd3; cmp_ref = '0; base_addr = 16'h0020; addend = 16'h5555;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && waitc < 500) begin
            @(negedge clk);
            waitc++;
        end
        check(done == 1'b1, {"R7 done seen ", name}, done, 1);
        check(busy == 1'b0, {"R6 idle at done ", name}, busy, 0);
        @(negedge clk);
        check(done == 1'b0, {"R7 done one cycle ", name}, done, 0);
        check(rd_q.size() == 0, {"R2 reads missing ", name}, rd_q.size(), 0);
        check(wr_q.size() == 0, {"R3 writes missing ", name}, wr_q.size(), 0);
        check(acc_cnt == 2 * nact, {"R10 access count ", name}, acc_cnt, 2 * nact);
        for (int i = 0; i < MW; i++) begin
            if (mem[i] != exp_mem[i]) check(0, {"R4 memory word ", name}, mem[i], exp_mem[i]);
        end
        check(1, "R4 memory compare", 0, 0);
        rd_q.delete();
        wr_q.delete();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!ended) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : driver
        logic [NE*DW-1:0] v;
        for (int i = 0; i < MW; i++) exp_mem[i] = init_word(i);
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req, "R9 reset outputs", {busy, done, mem_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_req, "R9 after reset", {busy, done, mem_req}, 0);

        // R1 not-equal, sparse mask 0b1010_0110
        v = '0;
        v[1*DW +: DW] = 16'h0007; v[2*DW +: DW] = 16'h0001;
        v[5*DW +: DW] = 16'hFFFF; v[7*DW +: DW] = 16'h0042;
        run_case(2'd1, v, 16'h0000, 16'h0000, 16'h0003, 1'b0, "ne_sparse");

        // R10 equal, all active
        for (int i = 0; i < NE; i++) v[i*DW +: DW] = 16'h00AA;
        run_case(2'd0, v, 16'h00AA, 16'h0010, 16'h0100, 1'b0, "eq_full");

        // R1 unsigned less-than, mixed values, R3 wrapping addend
        for (int i = 0; i < NE; i++) v[i*DW +: DW] = DW'(i * 16'h2000);
        run_case(2'd2, v, 16'h7000, 16'h0040, 16'hF800, 1'b0, "ltu_mixed");

        // R5 greater-or-equal, nothing active
        for (int i = 0; i < NE; i++) v[i*DW +: DW] = DW'(i);
        run_case(2'd3, v, 16'h0100, 16'h0000, 16'h1111, 1'b0, "geu_none");
        check(acc_cnt == 0, "R5 zero mask accesses", acc_cnt, 0);

        // R1 equal, only the top element
        v = '0;
        v[7*DW +: DW] = 16'h1234;
        run_case(2'd0, v, 16'h1234, 16'h0060, 16'h0001, 1'b0, "eq_top");

        // R6 start pulse during a run is ignored
        for (int i = 0; i < NE; i++) v[i*DW +: DW] = (i % 3 == 0) ? 16'h0000 : 16'h0009;
        run_case(2'd1, v, 16'h0000, 16'h0010, 16'h0020, 1'b1, "ne_poke");

        ended = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule